// File: doc/BRIEF.md
# Interrupt Acceptance and Dispatch Unit

This unit is the interrupt front end of one processor. It receives interrupt messages that each carry a destination ID, a delivery type and an 8-bit vector. A message whose destination is neither this unit's ID nor the broadcast ID is consumed and has no effect. Accepted messages of a special delivery type skip all pending state and are handed to the core on a separate port. Accepted ordinary (fixed) messages set one bit in a 256-entry pending set.

Fixed interrupts leave the pending set one at a time, highest vector first. A pending vector is offered to the core only when its priority class (vector bits [7:4]) is strictly above an effective priority. That effective priority is the larger of the core's priority input and the class of the highest vector now in service. When the core acknowledges an offered vector, the vector moves from pending to in service. An end-of-interrupt strobe retires the highest in-service vector. Because of the in-service term, a handler can be interrupted only by a vector of a strictly higher class.

Top module: `intr_accept_unit`

## Requirements
- R1: A message is accepted only when its destination equals `local_id` or is all ones. Any other message still completes its handshake but changes no pending state and produces no special output.
- R2: Delivery type codes 3'b010, 3'b100, 3'b101, 3'b110 and 3'b111 are special. One cycle after acceptance, such a message appears on `spec_valid`/`spec_type`/`spec_vec` and stays there until a cycle with `spec_ack` high. It never enters the pending set.
- R3: While a special message is held on the special port, `msg_ready` is low and the held type and vector do not change.
- R4: Type codes 3'b000, 3'b001 and 3'b011 are fixed. An accepted fixed message marks its vector pending. A second message for a vector that is already pending is absorbed, and the vector is offered only once.
- R5: When several vectors are pending, `disp_vec` is the highest pending vector number.
- R6: `disp_valid` is high only when the class (bits [7:4]) of the highest pending vector is strictly greater than both `proc_prio` and the class of the highest in-service vector. As a result, vectors 0 to 15 are never offered.
- R7: On a clock edge where `disp_valid` and `disp_ack` are both high, the offered vector leaves the pending set and enters service. It is not offered again until it is requested anew.
- R8: An `eoi` pulse retires only the highest in-service vector. An `eoi` pulse with nothing in service has no effect.
- R9: After reset, nothing is pending or in service, `spec_valid` and `disp_valid` are low and `msg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_id | input | 4 | This unit's destination ID |
| msg_valid | input | 1 | Incoming message valid |
| msg_ready | output | 1 | Unit can take a message |
| msg_dest | input | 4 | Message destination ID, all ones = broadcast |
| msg_type | input | 3 | Message delivery type code |
| msg_vec | input | 8 | Message vector |
| spec_valid | output | 1 | Special interrupt held for the core |
| spec_type | output | 3 | Held special delivery type |
| spec_vec | output | 8 | Held special vector |
| spec_ack | input | 1 | Core takes the held special interrupt |
| disp_valid | output | 1 | A fixed vector is offered to the core |
| disp_vec | output | 8 | Offered fixed vector |
| disp_ack | input | 1 | Core accepts the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| proc_prio | input | 4 | Core priority class |

## Verification
The assertions assume that `eoi`, `disp_ack` and `spec_ack` are single-cycle pulses, and that `disp_ack` is meaningful only while `disp_valid` is high. They also assume `msg_valid` is held until `msg_ready` is seen. The stimulus keeps within these limits in three ways. The core-side acknowledges are driven only by the bench's monitor, in a cycle where it has just seen the matching valid. The end-of-interrupt pulse lasts exactly one cycle. The driver task raises a message and lowers it only after the cycle in which `msg_ready` was high.

// File: rtl/intr_pkg.sv
// Package: delivery type codes and shared helpers for the interrupt
// acceptance unit. Assumes a 3-bit delivery type field.
package intr_pkg;

    localparam int TYPE_W = 3;

    localparam logic [TYPE_W-1:0] DLV_FIXED  = 3'b000;
    localparam logic [TYPE_W-1:0] DLV_LOWPRI = 3'b001;
    localparam logic [TYPE_W-1:0] DLV_SMI    = 3'b010;
    localparam logic [TYPE_W-1:0] DLV_RSVD   = 3'b011;
    localparam logic [TYPE_W-1:0] DLV_NMI    = 3'b100;
    localparam logic [TYPE_W-1:0] DLV_INIT   = 3'b101;
    localparam logic [TYPE_W-1:0] DLV_SIPI   = 3'b110;
    localparam logic [TYPE_W-1:0] DLV_EXTINT = 3'b111;

    // True for types that bypass the pending set and go straight to the core.
    function automatic logic is_special(input logic [TYPE_W-1:0] t);
        return (t == DLV_SMI) || t[2];
    endfunction

endpackage

// File: rtl/intr_prio_enc.sv
// Module: intr_prio_enc
// Finds the highest set bit of a vector. Assumes IDX_W bits can index N.
// Outputs are purely combinational.
module intr_prio_enc #(
    parameter int N     = 256,
    parameter int IDX_W = 8
) (
    input  logic [N-1:0]     bits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan upward so that the last (highest) set bit wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intr_msg_filter.sv
// Module: intr_msg_filter
// Checks the destination of each incoming message and splits accepted
// messages into two paths. Special types go to a holding register;
// fixed types produce a one-cycle set request for the pending set.
// Assumes all ones in the destination field means broadcast.
module intr_msg_filter
    import intr_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   local_id,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [ID_W-1:0]   msg_dest,
    input  logic [TYPE_W-1:0] msg_type,
    input  logic [VEC_W-1:0]  msg_vec,
    output logic              spec_valid,
    output logic [TYPE_W-1:0] spec_type,
    output logic [VEC_W-1:0]  spec_vec,
    input  logic              spec_ack,
    output logic              fix_set,
    output logic [VEC_W-1:0]  fix_vec
);

    logic addressed;
    logic take;
    logic hold_q;
    logic [TYPE_W-1:0] type_q;
    logic [VEC_W-1:0]  vec_q;

    // Destination match: exact ID or broadcast.
    always_comb begin
        addressed = (msg_dest == local_id) || (msg_dest == {ID_W{1'b1}});
        take      = msg_valid && msg_ready && addressed;
        fix_set   = take && !is_special(msg_type);
        fix_vec   = msg_vec;
    end

    assign msg_ready  = !hold_q;
    assign spec_valid = hold_q;
    assign spec_type  = type_q;
    assign spec_vec   = vec_q;

    // Holding register for a special message until the core takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            type_q <= '0;
            vec_q  <= '0;
        end else if (hold_q) begin
            if (spec_ack) hold_q <= 1'b0;
        end else if (take && is_special(msg_type)) begin
            hold_q <= 1'b1;
            type_q <= msg_type;
            vec_q  <= msg_vec;
        end
    end

endmodule

// File: rtl/intr_vec_store.sv
// Module: intr_vec_store
// Holds the pending and in-service bit sets, one bit per vector.
// Per edge, pending = (pending & ~acked) | arriving, and
// in-service = (in-service & ~retired) | acked.
// Assumes the caller passes a retire index only when in-service is non-empty.
module intr_vec_store #(
    parameter int VEC_W = 8,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [VEC_W-1:0] set_vec_i,
    input  logic             ack_i,
    input  logic [VEC_W-1:0] ack_vec_i,
    input  logic             ret_i,
    input  logic [VEC_W-1:0] ret_vec_i,
    output logic [NVEC-1:0]  pend_o,
    output logic [NVEC-1:0]  serv_o
);

    logic [NVEC-1:0] set_m, ack_m, ret_m;

    // One-hot masks for each update source.
    always_comb begin
        set_m = set_i ? (NVEC'(1) << set_vec_i) : '0;
        ack_m = ack_i ? (NVEC'(1) << ack_vec_i) : '0;
        ret_m = ret_i ? (NVEC'(1) << ret_vec_i) : '0;
    end

    // Register update for both bit sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= '0;
            serv_o <= '0;
        end else begin
            pend_o <= (pend_o & ~ack_m) | set_m;
            serv_o <= (serv_o & ~ret_m) | ack_m;
        end
    end

endmodule

// File: rtl/intr_accept_unit.sv
// Module: intr_accept_unit (top)
// Per-processor interrupt front end: filters messages, forwards special
// types, and offers fixed vectors to the core highest first. A vector is
// offered only when its class is above both the core priority and the
// class of the highest in-service vector. Assumes disp_ack is asserted
// only while disp_valid is high.
module intr_accept_unit
    import intr_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int VEC_W  = 8,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   local_id,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [ID_W-1:0]   msg_dest,
    input  logic [2:0]        msg_type,
    input  logic [VEC_W-1:0]  msg_vec,
    output logic              spec_valid,
    output logic [2:0]        spec_type,
    output logic [VEC_W-1:0]  spec_vec,
    input  logic              spec_ack,
    output logic              disp_valid,
    output logic [VEC_W-1:0]  disp_vec,
    input  logic              disp_ack,
    input  logic              eoi,
    input  logic [PRIO_W-1:0] proc_prio
);

    localparam int NVEC = 1 << VEC_W;

    logic             fix_set;
    logic [VEC_W-1:0] fix_vec;
    logic [NVEC-1:0]  irr_q, isr_q;
    logic             pend_any, serv_any;
    logic [VEC_W-1:0] pend_top, serv_top;
    logic [PRIO_W-1:0] pend_cls, serv_cls, eff_prio;
    logic             do_ack, do_ret;

    intr_msg_filter #(.ID_W(ID_W), .VEC_W(VEC_W)) filt_i (
        .clk(clk), .rst_n(rst_n), .local_id(local_id),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_dest(msg_dest), .msg_type(msg_type), .msg_vec(msg_vec),
        .spec_valid(spec_valid), .spec_type(spec_type), .spec_vec(spec_vec),
        .spec_ack(spec_ack), .fix_set(fix_set), .fix_vec(fix_vec)
    );

    intr_prio_enc #(.N(NVEC), .IDX_W(VEC_W)) pend_enc_i (
        .bits_i(irr_q), .any_o(pend_any), .idx_o(pend_top)
    );

    intr_prio_enc #(.N(NVEC), .IDX_W(VEC_W)) serv_enc_i (
        .bits_i(isr_q), .any_o(serv_any), .idx_o(serv_top)
    );

    // Effective priority and the dispatch decision.
    always_comb begin
        pend_cls   = pend_top[VEC_W-1 -: PRIO_W];
        serv_cls   = serv_any ? serv_top[VEC_W-1 -: PRIO_W] : '0;
        eff_prio   = (serv_cls > proc_prio) ? serv_cls : proc_prio;
        disp_valid = pend_any && (pend_cls > eff_prio);
        disp_vec   = pend_top;
        do_ack     = disp_valid && disp_ack;
        do_ret     = eoi && serv_any;
    end

    intr_vec_store #(.VEC_W(VEC_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .set_i(fix_set), .set_vec_i(fix_vec),
        .ack_i(do_ack), .ack_vec_i(pend_top),
        .ret_i(do_ret), .ret_vec_i(serv_top),
        .pend_o(irr_q), .serv_o(isr_q)
    );

endmodule

// File: rtl/intr_accept_unit_chk.sv
// Module: intr_accept_unit_chk
// Assertion checker bound to intr_accept_unit. It reads the ports plus
// the pending and in-service sets.
module intr_accept_unit_chk #(
    parameter int ID_W   = 4,
    parameter int VEC_W  = 8,
    parameter int PRIO_W = 4,
    localparam int NVEC  = 1 << VEC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   local_id,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [ID_W-1:0]   msg_dest,
    input logic [2:0]        msg_type,
    input logic [VEC_W-1:0]  msg_vec,
    input logic              spec_valid,
    input logic [2:0]        spec_type,
    input logic [VEC_W-1:0]  spec_vec,
    input logic              spec_ack,
    input logic              disp_valid,
    input logic [VEC_W-1:0]  disp_vec,
    input logic              disp_ack,
    input logic              eoi,
    input logic [PRIO_W-1:0] proc_prio,
    input logic [NVEC-1:0]   irr,
    input logic [NVEC-1:0]   isr
);

    logic hit, miss, special;
    assign hit     = (msg_dest == local_id) || (msg_dest == {ID_W{1'b1}});
    assign miss    = msg_valid && msg_ready && !hit;
    assign special = (msg_type == 3'b010) || msg_type[2];

    p_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !spec_valid);

    p_special_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && hit && special)
        |=> (spec_valid && spec_vec == $past(msg_vec) && spec_type == $past(msg_type)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_valid && !spec_ack)
        |=> (spec_valid && !msg_ready && $stable(spec_vec) && $stable(spec_type)));

    p_no_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && hit && !special && irr[msg_vec] && !(disp_valid && disp_ack))
        |=> ($countones(irr) == $countones($past(irr))));

    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_vec[VEC_W-1 -: PRIO_W] > proc_prio));

    p_ack_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ack) |=> (!disp_valid || disp_vec != $past(disp_vec)));

    p_eoi_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr != '0 && !(disp_valid && disp_ack))
        |=> ($countones(isr) + 1 == $countones($past(isr))));

    p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr == '0 && !(disp_valid && disp_ack)) |=> (isr == '0));

endmodule

bind intr_accept_unit intr_accept_unit_chk #(
    .ID_W(ID_W), .VEC_W(VEC_W), .PRIO_W(PRIO_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .local_id(local_id),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_type(msg_type), .msg_vec(msg_vec),
    .spec_valid(spec_valid), .spec_type(spec_type), .spec_vec(spec_vec),
    .spec_ack(spec_ack), .disp_valid(disp_valid), .disp_vec(disp_vec),
    .disp_ack(disp_ack), .eoi(eoi), .proc_prio(proc_prio),
    .irr(irr_q), .isr(isr_q)
);

// File: tb/intr_accept_unit_tb_top.sv
// Scoreboard bench: driver tasks push expected items, monitors pop and compare.
module intr_accept_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] local_id = 4'h5;
    logic       msg_valid = 1'b0;
    logic       msg_ready;
    logic [3:0] msg_dest = '0;
    logic [2:0] msg_type = '0;
    logic [7:0] msg_vec = '0;
    logic       spec_valid;
    logic [2:0] spec_type;
    logic [7:0] spec_vec;
    logic       spec_ack = 1'b0;
    logic       disp_valid;
    logic [7:0] disp_vec;
    logic       disp_ack = 1'b0;
    logic       eoi = 1'b0;
    logic [3:0] proc_prio = '0;

    int errors = 0;
    int checks = 0;
    bit core_en = 0;
    bit spec_hold = 0;
    logic [10:0] spec_q[$];
    logic [7:0]  disp_q[$];

    always #10 clk = ~clk;

    intr_accept_unit dut_i (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [3:0] dst, input logic [2:0] typ, input logic [7:0] vec);
        bit spcl;
        spcl = (typ == 3'b010) || typ[2];
        if ((dst == local_id || dst == 4'hF) && spcl) spec_q.push_back({typ, vec});
        @(posedge clk); #1;
        msg_valid = 1'b1; msg_dest = dst; msg_type = typ; msg_vec = vec;
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        @(posedge clk); #1;
        msg_valid = 1'b0;
    endtask

    task automatic pulse_eoi();
        @(posedge clk); #1 eoi = 1'b1;
        @(posedge clk); #1 eoi = 1'b0;
    endtask

    task automatic set_prio(input logic [3:0] p);
        @(posedge clk); #1 proc_prio = p;
    endtask

    task automatic set_core(input bit en);
        @(posedge clk); #1 core_en = en;
    endtask

    // Monitor: compare special-port and dispatch-port output against queues.
    always @(negedge clk) begin
        spec_ack = 1'b0;
        disp_ack = 1'b0;
        if (rst_n && spec_valid && !spec_hold) begin
            if (spec_q.size() == 0) check(0, "R1/R2 unexpected special", {spec_type, spec_vec}, 0);
            else begin
                logic [10:0] e;
                e = spec_q.pop_front();
                check({spec_type, spec_vec} == e, "R2 special type/vector", {spec_type, spec_vec}, e);
            end
            spec_ack = 1'b1;
        end
        if (rst_n && core_en && disp_valid) begin
            if (disp_q.size() == 0) check(0, "R6/R7 unexpected dispatch", disp_vec, 0);
            else begin
                logic [7:0] e;
                e = disp_q.pop_front();
                check(disp_vec == e, "R5 dispatch order", disp_vec, e);
            end
            disp_ack = 1'b1;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        check(!disp_valid, "R9 disp_valid", disp_valid, 0);
        check(!spec_valid, "R9 spec_valid", spec_valid, 0);
        check(msg_ready, "R9 msg_ready", msg_ready, 1);

        // R2: special types, own ID and broadcast; R1: a foreign ID is dropped
        send(4'h5, 3'b100, 8'h02);
        send(4'hF, 3'b101, 8'h00);
        send(4'h3, 3'b010, 8'h33);
        send(4'h5, 3'b110, 8'h9A);
        send(4'h5, 3'b111, 8'h21);
        idle(3);
        check(spec_q.size() == 0, "R2 all specials seen", spec_q.size(), 0);

        // R3: held special blocks input
        spec_hold = 1;
        send(4'h5, 3'b010, 8'h44);
        idle(3);
        check(spec_valid && spec_vec == 8'h44, "R3 held vector", spec_vec, 8'h44);
        check(!msg_ready, "R3 msg_ready low", msg_ready, 0);
        spec_hold = 0;
        idle(2);
        check(spec_q.size() == 0 && msg_ready, "R3 released", spec_q.size(), 0);

        // R1: fixed message to a foreign ID
        send(4'h3, 3'b000, 8'h80);
        idle(2);
        check(!disp_valid, "R1 foreign fixed ignored", disp_valid, 0);

        // R6: gating by proc_prio
        set_prio(4'hF);
        send(4'h5, 3'b000, 8'h45);
        send(4'hF, 3'b001, 8'h92);
        idle(1);
        check(!disp_valid, "R6 gated at prio F", disp_valid, 0);
        set_prio(4'h8);
        idle(1);
        check(disp_valid && disp_vec == 8'h92, "R6 class 9 over prio 8", disp_vec, 8'h92);
        set_prio(4'h9);
        idle(1);
        check(!disp_valid, "R6 class equal to prio", disp_valid, 0);
        set_prio(4'h0);

        // R7: ack moves to service; lower class then blocked
        disp_q.push_back(8'h92);
        set_core(1);
        idle(3);
        check(disp_q.size() == 0, "R7 0x92 taken", disp_q.size(), 0);
        check(!disp_valid, "R7 0x45 blocked by in-service", disp_valid, 0);
        disp_q.push_back(8'h45);
        pulse_eoi();
        idle(3);
        check(disp_q.size() == 0, "R8 eoi frees 0x45", disp_q.size(), 0);

        // R6 nesting and R8 retiring only the highest
        send(4'h5, 3'b000, 8'h30);
        idle(2);
        check(!disp_valid, "R6 0x30 below in-service", disp_valid, 0);
        disp_q.push_back(8'h60);
        send(4'h5, 3'b000, 8'h60);
        idle(3);
        check(disp_q.size() == 0, "R6 nested 0x60", disp_q.size(), 0);
        pulse_eoi();
        idle(3);
        check(!disp_valid, "R8 only 0x60 retired", disp_valid, 0);
        disp_q.push_back(8'h30);
        pulse_eoi();
        idle(3);
        check(disp_q.size() == 0, "R8 0x30 after second eoi", disp_q.size(), 0);
        pulse_eoi();
        idle(2);
        pulse_eoi();
        idle(2);
        check(!disp_valid && msg_ready, "R8 eoi on empty", disp_valid, 0);

        // R4: duplicate absorbed
        set_core(0);
        send(4'h5, 3'b000, 8'h70);
        send(4'h5, 3'b000, 8'h70);
        disp_q.push_back(8'h70);
        set_core(1);
        idle(4);
        check(disp_q.size() == 0, "R4 0x70 once", disp_q.size(), 0);
        check(!disp_valid, "R4 no second 0x70", disp_valid, 0);
        pulse_eoi();
        idle(2);

        // R5: highest vector first within one class
        set_core(0);
        send(4'h5, 3'b000, 8'h51);
        send(4'h5, 3'b000, 8'h5F);
        send(4'h5, 3'b011, 8'h50);
        idle(1);
        check(disp_valid && disp_vec == 8'h5F, "R5 highest offered", disp_vec, 8'h5F);
        disp_q.push_back(8'h5F);
        set_core(1);
        idle(3);
        disp_q.push_back(8'h51);
        pulse_eoi();
        idle(3);
        disp_q.push_back(8'h50);
        pulse_eoi();
        idle(3);
        pulse_eoi();
        idle(2);
        check(disp_q.size() == 0, "R5 order complete", disp_q.size(), 0);

        // R6: class 0 never offered
        send(4'h5, 3'b000, 8'h0A);
        idle(3);
        check(!disp_valid, "R6 class 0 never offered", disp_valid, 0);

        check(spec_q.size() == 0 && disp_q.size() == 0, "R2/R5 queues drained",
              spec_q.size() + disp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule